// File: doc/BRIEF.md
# Serial Transmit DMA Engine

This block moves a buffer of bytes from system memory to a serial transmitter without processor involvement. Software first writes a start address into the pointer register, then writes a byte count; the count write itself launches the transfer. The engine then walks the buffer one byte at a time. For each byte it issues a single-byte memory read, waits for the acknowledge, and presents the returned byte on a valid/ready byte stream toward the transmitter. Once the transmitter takes the byte, the pointer moves forward by one.

The pointer is always visible as a live value. After a transfer it points one past the last byte sent, so software can queue the next contiguous buffer by writing only a new count. While a transfer runs, a busy flag is raised and further configuration writes are dropped. A one-cycle done pulse marks the acceptance of the final byte. When no transmitter is attached, a count write only advances the pointer by that count, and no memory traffic is generated.

Register decode and bus arbitration sit outside this block. The host interface supplies one-cycle write strobes with their data.

Top module: `txdma_engine`

## Requirements
- R1: After a synchronous reset the pointer reads 0, and busy, done, the memory request and the stream valid are all low.
- R2: An address write while idle makes the pointer output show the written value on the next cycle.
- R3: A nonzero count write while idle with the transmitter attached raises busy on the next cycle, together with a memory request at the pointer.
- R4: A count write of zero changes nothing: the pointer keeps its value, busy stays low and no request is issued.
- R5: For a count of N, exactly N bytes are sent in address order. Each memory request carries the current pointer, each streamed byte equals the data returned for that address, and the pointer advances by one (modulo 2^32) when the stream handshake completes.
- R6: A memory request stays asserted with a stable address until it is acknowledged. The stream valid stays asserted with stable data until ready. A memory request and the stream valid are never high together.
- R7: Done pulses high for exactly one cycle, in the cycle after the last byte's stream handshake. In that same cycle busy is low and the pointer equals the start address plus N. A count-only write that follows continues from that pointer.
- R8: While busy, count writes and address writes are ignored. The running transfer still sends exactly its original N bytes from its original addresses.
- R9: With no transmitter attached, a nonzero count write advances the pointer by the count on the next cycle. No memory request is issued, and busy and done stay low.
- R10: If an address write and a count write arrive in the same idle cycle, the transfer starts from the newly written address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_we | input | 1 | One-cycle strobe: write pointer |
| cfg_addr_wdata | input | 32 | New pointer value |
| cfg_cnt_we | input | 1 | One-cycle strobe: write byte count (starts a transfer) |
| cfg_cnt_wdata | input | 16 | Byte count |
| tx_attached | input | 1 | High when a transmitter is connected |
| ptr_o | output | 32 | Live pointer readback |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the last byte is accepted |
| mem_req | output | 1 | Single-byte memory read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_ack | input | 1 | Memory acknowledge; data valid with it |
| mem_rdata | input | 8 | Returned byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_ready | input | 1 | Transmitter accepts the byte |

## Verification
The bench stalls both the acknowledge and the ready at random. An engine that sampled data or advanced the pointer on a cycle without a handshake would then send bytes that are duplicated or skipped. Count and address writes are injected in the middle of a transfer, where an unguarded engine would restart or retarget the transfer and send the wrong number of bytes or read from the wrong addresses. Buffers that wrap past the top of the address space, coincident address and count writes, zero counts and the detached-transmitter skip are also exercised. A design that got any of these wrong would start from the stale address, move on a zero count, or touch memory when it should only add.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SEND  = 2'd2
  } txdma_state_e;
endpackage

// File: rtl/txdma_ptr.sv
module txdma_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  logic          bulk_en,
  input  logic [AW-1:0] bulk_cnt,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] base;
  logic [AW-1:0] incr;

  always_comb begin
    base = load_en ? load_val : ptr;
    if (bulk_en)      incr = bulk_cnt;
    else if (step_en) incr = AW'(1);
    else              incr = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                               ptr <= '0;
    else if (load_en || step_en || bulk_en) ptr <= base + incr;
  end
endmodule

// File: rtl/txdma_count.sv
module txdma_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          dec_en,
  output logic          last
);
  logic [CW-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst)          remaining <= '0;
    else if (load_en) remaining <= load_val;
    else if (dec_en)  remaining <= remaining - CW'(1);
  end

  assign last = (remaining == CW'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec_en |-> remaining != '0); // R5
endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
  import txdma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mem_ack,
  input  logic tx_ready,
  input  logic last,
  output logic mem_req,
  output logic tx_valid,
  output logic busy,
  output logic done,
  output logic cap,
  output logic beat
);
  txdma_state_e state;

  assign cap  = (state == ST_FETCH) && mem_ack;
  assign beat = (state == ST_SEND) && tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_req  <= 1'b0;
      tx_valid <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_FETCH;
          mem_req <= 1'b1;
          busy    <= 1'b1;
        end
        ST_FETCH: if (mem_ack) begin
          state    <= ST_SEND;
          mem_req  <= 1'b0;
          tx_valid <= 1'b1;
        end
        ST_SEND: if (tx_ready) begin
          tx_valid <= 1'b0;
          if (last) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            state   <= ST_FETCH;
            mem_req <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req); // R6
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && tx_valid)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !tx_valid); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy && !(tx_valid && tx_ready) |=> busy); // R8
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_addr_we,
  input  logic [AW-1:0] cfg_addr_wdata,
  input  logic          cfg_cnt_we,
  input  logic [CW-1:0] cfg_cnt_wdata,
  input  logic          tx_attached,
  output logic [AW-1:0] ptr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready
);
  localparam int PAD = AW - CW;

  logic accept_cnt, start, skip, load, cap, beat, last;
  logic [AW-1:0] cnt_ext;

  assign accept_cnt = cfg_cnt_we && (cfg_cnt_wdata != '0) && !busy_o;
  assign start      = accept_cnt && tx_attached;
  assign skip       = accept_cnt && !tx_attached;
  assign load       = cfg_addr_we && !busy_o;
  assign cnt_ext    = {{PAD{1'b0}}, cfg_cnt_wdata};

  txdma_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst),
    .load_en(load), .load_val(cfg_addr_wdata),
    .step_en(beat), .bulk_en(skip), .bulk_cnt(cnt_ext),
    .ptr(ptr_o)
  );

  txdma_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst),
    .load_en(start), .load_val(cfg_cnt_wdata),
    .dec_en(beat), .last(last)
  );

  txdma_seq u_seq (
    .clk(clk), .rst(rst),
    .start(start), .mem_ack(mem_ack), .tx_ready(tx_ready), .last(last),
    .mem_req(mem_req), .tx_valid(tx_valid), .busy(busy_o), .done(done_o),
    .cap(cap), .beat(beat)
  );

  assign mem_addr = ptr_o;

  always_ff @(posedge clk) begin
    if (rst)      tx_data <= '0;
    else if (cap) tx_data <= mem_rdata;
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> $stable(mem_addr)); // R6
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> $stable(tx_data)); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> ptr_o == $past(ptr_o) + AW'(1)); // R5
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy_o && !(tx_valid && tx_ready) |=> $stable(ptr_o)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R7
endmodule

// File: tb/test_txdma_engine.sv
module test_txdma_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_addr_we = 1'b0;
  logic [31:0] cfg_addr_wdata = '0;
  logic        cfg_cnt_we = 1'b0;
  logic [15:0] cfg_cnt_wdata = '0;
  logic        tx_attached = 1'b1;
  logic [31:0] ptr_o;
  logic        busy_o, done_o, mem_req, tx_valid;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] seed_sink;

  always #4 clk = ~clk;

  txdma_engine i_txdma_engine (
    .clk(clk), .rst(rst),
    .cfg_addr_we(cfg_addr_we), .cfg_addr_wdata(cfg_addr_wdata),
    .cfg_cnt_we(cfg_cnt_we), .cfg_cnt_wdata(cfg_cnt_wdata),
    .tx_attached(tx_attached), .ptr_o(ptr_o), .busy_o(busy_o), .done_o(done_o),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Called at the negedge right after the count strobe was cleared.
  task automatic run_xfer(input logic [31:0] base, input int n, input bit poke);
    logic [31:0] ep = base;
    int got = 0;
    bit seen = 1'b0;
    chk(busy_o == 1'b1, "R3 busy after start", 32'(busy_o), 1);
    chk(mem_req == 1'b1 && mem_addr == base, "R3 first request address", mem_addr, base);
    for (int it = 1; it < 3000 && !seen; it++) begin
      if (done_o) begin
        seen = 1'b1;
        chk(busy_o == 1'b0, "R7 busy low with done", 32'(busy_o), 0);
        chk(got == n, "R5 byte count", 32'(got), 32'(n));
        chk(ptr_o == base + 32'(n), "R7 final pointer", ptr_o, base + 32'(n));
      end else begin
        chk(!(mem_req && tx_valid), "R6 request and valid exclusive", 32'({mem_req, tx_valid}), 0);
        cfg_cnt_we     = poke && (it == 3);
        cfg_cnt_wdata  = 16'd7;
        cfg_addr_we    = poke && (it == 3);
        cfg_addr_wdata = 32'h1234_0000;
        mem_ack = mem_req && ($urandom_range(0, 2) != 0);
        if (mem_ack) chk(mem_addr == ep, "R5 fetch address", mem_addr, ep);
        mem_rdata = mem_byte(mem_addr);
        tx_ready = ($urandom_range(0, 2) != 0);
        if (tx_valid && tx_ready) begin
          chk(tx_data == mem_byte(ep), "R5 streamed byte", 32'(tx_data), 32'(mem_byte(ep)));
          ep++;
          got++;
        end
        @(negedge clk);
      end
    end
    if (!seen) chk(1'b0, "R7 done never seen", 0, 1);
    mem_ack = 1'b0; tx_ready = 1'b0; cfg_cnt_we = 1'b0; cfg_addr_we = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done lasts one cycle", 32'(done_o), 0);
    if (poke) chk(ptr_o == base + 32'(n), "R8 busy writes ignored", ptr_o, base + 32'(n));
  endtask

  task automatic set_addr(input logic [31:0] a);
    @(negedge clk);
    cfg_addr_we = 1'b1; cfg_addr_wdata = a;
    @(negedge clk);
    cfg_addr_we = 1'b0;
    chk(ptr_o == a, "R2 address load", ptr_o, a);
  endtask

  task automatic write_cnt(input int n);
    cfg_cnt_we = 1'b1; cfg_cnt_wdata = 16'(n);
    @(negedge clk);
    cfg_cnt_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ptr_o == 0, "R1 reset pointer", ptr_o, 0);
    chk({busy_o, done_o, mem_req, tx_valid} == 4'b0, "R1 reset flags",
        32'({busy_o, done_o, mem_req, tx_valid}), 0);

    // R4: zero count
    set_addr(32'h100);
    write_cnt(0);
    chk(ptr_o == 32'h100, "R4 zero count pointer", ptr_o, 32'h100);
    chk(!busy_o && !mem_req, "R4 zero count idle", 32'({busy_o, mem_req}), 0);
    @(negedge clk);
    chk(!busy_o && !mem_req, "R4 zero count still idle", 32'({busy_o, mem_req}), 0);

    // directed single byte and wrap with busy writes (R5, R8)
    set_addr(32'h40);
    write_cnt(1);
    run_xfer(32'h40, 1, 1'b0);
    set_addr(32'hFFFF_FFFE);
    write_cnt(5);
    run_xfer(32'hFFFF_FFFE, 5, 1'b1);

    // R7: chaining continues from live pointer (now 3)
    write_cnt(2);
    run_xfer(32'h3, 2, 1'b0);

    // R10: coincident address and count writes
    cfg_addr_we = 1'b1; cfg_addr_wdata = 32'h2000;
    write_cnt(3);
    cfg_addr_we = 1'b0;
    run_xfer(32'h2000, 3, 1'b0);

    // R9: no transmitter attached
    tx_attached = 1'b0;
    set_addr(32'h500);
    write_cnt(300);
    chk(ptr_o == 32'h500 + 32'd300, "R9 bulk advance", ptr_o, 32'h500 + 32'd300);
    chk({busy_o, done_o, mem_req} == 3'b0, "R9 no activity", 32'({busy_o, done_o, mem_req}), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk({busy_o, done_o, mem_req} == 3'b0, "R9 stays quiet", 32'({busy_o, done_o, mem_req}), 0);
    end
    tx_attached = 1'b1;

    // random transfers
    for (int t = 0; t < 25; t++) begin
      logic [31:0] a = $urandom();
      int n = $urandom_range(1, 12);
      set_addr(a);
      write_cnt(n);
      run_xfer(a, n, (n >= 4) && ($urandom_range(0, 1) == 1));
    end

    summary();
    $finish;
  end
endmodule